// File: doc/BRIEF.md
# Buffered Full-Duplex SPI Master

This block is a full-duplex SPI master that polling software drives through a few strobes. A frame written by software first goes into a one-entry holding buffer. It moves into the transmit shifter as soon as the shifter is free. Each received frame is moved whole into a receive register. Four flags show the state of the block: transmit-empty, receive-full, overrun and busy.

The two data flags change at different points in a frame. Transmit-empty comes back at the start of a frame, while receive-full comes up only at its end. Because of this, software can keep one frame shifting and a second one waiting. When the waiting frame starts on the next bit period, the serial clock runs with no gap between frames. When nothing is waiting at the end of a frame, the clock stops low until software writes again.

Frames are `DATA_W` bits long and are sent most significant bit first in SPI mode 0. In this mode SCLK idles low, the master samples MISO on the rising edge and changes MOSI while SCLK is low. The SCLK half-period is `divHalf` system clock cycles.

Top module: `spi_buf_master`

## Requirements
- R1: A write strobe while `txEmpty` is high captures `wrData` into the holding buffer, and `txEmpty` reads low on the following cycle.
- R2: `txEmpty` returns high on the clock edge where the buffered frame moves into the shifter. This happens at the start of the frame's first bit period, before the first rising SCLK edge, and not at the end of the frame.
- R3: `rxFull` rises exactly `16*H` cycles after a frame starts, where H is the effective half-period. That edge is the one on which SCLK falls for the last time in the frame. `rdData` then holds the received frame, with the first sampled bit as its most significant bit.
- R4: If the holding buffer is full when a frame ends, the next frame starts at once. Rising SCLK edges stay exactly `2*H` cycles apart across the frame boundary.
- R5: If the holding buffer is empty when a frame ends, `busy` drops and SCLK stays low on that same edge.
- R6: If a frame completes while `rxFull` is high and no read happens in that cycle, `rdData` takes the new frame and `overrun` sets. `overrun` stays set, even across reads, until `ovrClr` is pulsed.
- R7: With back-to-back traffic, `rxFull` for frame N is already high on the cycle when `txEmpty` rises because frame N+2 enters the shifter.
- R8: MOSI presents the transmitted frame most significant bit first and is stable at every rising SCLK edge. MISO is sampled on the rising edges.
- R9: The effective half-period H equals `divHalf` cycles, and values 0 and 1 both give H = 1, which divides the system clock by 2.
- R10: A write strobe while `txEmpty` is low is ignored. The frame already waiting in the buffer is the one transmitted.
- R11: A read strobe clears `rxFull` on the next cycle, and `rdData` keeps its value.
- R12: `busy` is high from the cycle a frame enters the shifter until the last back-to-back frame completes.
- R13: After reset, `txEmpty`=1, `rxFull`=0, `overrun`=0, `busy`=0 and `sclk`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divHalf | input | DIV_W | SCLK half-period in system clock cycles (0 is treated as 1) |
| wrStrobe | input | 1 | Data register write strobe |
| wrData | input | DATA_W | Frame to transmit |
| rdStrobe | input | 1 | Data register read strobe |
| ovrClr | input | 1 | Clears the overrun flag |
| rdData | output | DATA_W | Last received frame |
| txEmpty | output | 1 | Holding buffer can accept a frame |
| rxFull | output | 1 | Unread received frame present |
| overrun | output | 1 | Sticky: a received frame overwrote an unread one |
| busy | output | 1 | A frame is shifting |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with `DATA_W` = 8 and `DIV_W` = 4. With these values it can run single frames at `divHalf` set to 0, 3 and 15. These settings cover the zero-to-one mapping, an odd divider and the widest half-period the port allows, each with an exact cycle count from load to `rxFull`. A behavioural slave on the serial pins runs three-frame back-to-back streams at half-period 2. This exposes the boundary between frames and the ordering of flags across frames N and N+2.

// File: rtl/spi_pkg.sv
package spi_pkg;
  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic load;    // holding buffer -> transmit shifter
    logic sample;  // rising SCLK: capture MISO
    logic shift;   // falling SCLK inside a frame: next MOSI bit
    logic done;    // final falling SCLK: frame complete
  } ctrlStrobes_t;
endpackage

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             bufValid,
  output ctrlStrobes_t     strobes,
  output logic             sclk,
  output logic             busy
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfM1;
  logic [CNT_W-1:0] bitCnt;
  logic             active;
  logic             phase;   // 0: SCLK low half, 1: SCLK high half
  logic             tick;
  logic             lastBit;

  assign halfM1  = (divHalf == '0) ? '0 : divHalf - 1'b1;
  assign tick    = active && (divCnt >= halfM1);
  assign lastBit = (bitCnt == LAST_BIT);

  always_comb begin
    strobes = '0;
    if (!active) begin
      strobes.load = bufValid;
    end else if (tick) begin
      if (!phase) begin
        strobes.sample = 1'b1;
      end else if (lastBit) begin
        strobes.done = 1'b1;
        strobes.load = bufValid;
      end else begin
        strobes.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      bitCnt <= '0;
      active <= 1'b0;
      phase  <= 1'b0;
    end else if (!active) begin
      divCnt <= '0;
      bitCnt <= '0;
      phase  <= 1'b0;
      active <= bufValid;
    end else if (tick) begin
      divCnt <= '0;
      phase  <= !phase;
      if (phase) begin
        if (lastBit) begin
          bitCnt <= '0;
          active <= bufValid;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sclk = phase;
  assign busy = active;

  // R5: nothing waiting -> clock parks low and busy drops
  p_stop_when_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done && !bufValid |=> !busy && !sclk);

  // R4: something waiting -> shifting continues without a gap
  p_continue_when_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done && bufValid |=> busy && !sclk);

  // R12: a frame start raises busy
  p_busy_on_load_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> busy);
endmodule

// File: rtl/spi_dpath.sv
module spi_dpath
  import spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  input  logic              ovrClr,
  input  logic              miso,
  output logic              bufValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rxFull,
  output logic              overrun,
  output logic              mosi
);
  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              wrAccept;

  assign wrAccept = wrStrobe && !bufValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf    <= '0;
      bufValid <= 1'b0;
      txShift  <= '0;
      rxShift  <= '0;
      rdData   <= '0;
      rxFull   <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (wrAccept) begin
        txBuf    <= wrData;
        bufValid <= 1'b1;
      end else if (strobes.load) begin
        bufValid <= 1'b0;
      end

      if (strobes.load)
        txShift <= txBuf;
      else if (strobes.shift)
        txShift <= {txShift[DATA_W-2:0], 1'b0};

      if (strobes.sample)
        rxShift <= {rxShift[DATA_W-2:0], miso};

      if (strobes.done) begin
        rdData <= rxShift;
        rxFull <= 1'b1;
      end else if (rdStrobe) begin
        rxFull <= 1'b0;
      end

      if (strobes.done && rxFull && !rdStrobe)
        overrun <= 1'b1;
      else if (ovrClr)
        overrun <= 1'b0;
    end
  end

  assign mosi = txShift[DATA_W-1];

  // R2: moving a frame into the shifter frees the buffer
  p_load_frees_buffer_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !bufValid);

  // R3: completion publishes the assembled frame
  p_frame_published_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |=> rxFull && rdData == $past(rxShift));

  // R6: completion over unread data flags overrun
  p_overrun_flagged_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done && rxFull && !rdStrobe |=> overrun);

  // R10: a write into a full buffer leaves it untouched
  p_full_write_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && bufValid |=> $stable(txBuf));
endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  input  logic              ovrClr,
  output logic [DATA_W-1:0] rdData,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              overrun,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  ctrlStrobes_t strobes;
  logic         bufValid;

  spi_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .divHalf  (divHalf),
    .bufValid (bufValid),
    .strobes  (strobes),
    .sclk     (sclk),
    .busy     (busy)
  );

  spi_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrStrobe (wrStrobe),
    .wrData   (wrData),
    .rdStrobe (rdStrobe),
    .ovrClr   (ovrClr),
    .miso     (miso),
    .bufValid (bufValid),
    .rdData   (rdData),
    .rxFull   (rxFull),
    .overrun  (overrun),
    .mosi     (mosi)
  );

  assign txEmpty = !bufValid;

  // R1: an accepted write fills the buffer
  p_write_fills_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && txEmpty |=> !txEmpty);
endmodule

// File: tb/test_spi_buf_master.sv
module test_spi_buf_master;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DIV_W-1:0]  divHalf = '0;
  logic              wrStrobe = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdStrobe = 1'b0;
  logic              ovrClr = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              txEmpty, rxFull, overrun, busy, sclk, mosi, miso;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // behavioural slave
  logic [7:0] slvTx [0:15];
  logic [7:0] slvRx [0:15];
  int         slvIdx = 0;
  int         slvRxCnt = 0;
  int         capBits = 0;
  int         outBits = 0;
  logic [7:0] capSh = '0;
  logic [7:0] misoSh = '0;
  int         riseCycle [0:63];
  int         riseCnt = 0;

  always #10 clk = !clk;  // 50 MHz
  always @(negedge clk) cyc <= cyc + 1;

  spi_buf_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_spi_buf_master (
    .clk(clk), .rstN(rstN), .divHalf(divHalf), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdStrobe(rdStrobe), .ovrClr(ovrClr), .rdData(rdData), .txEmpty(txEmpty),
    .rxFull(rxFull), .overrun(overrun), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  assign miso = misoSh[7];

  always @(posedge sclk) begin
    capSh = {capSh[6:0], mosi};
    capBits = capBits + 1;
    if (capBits == 8) begin
      if (slvRxCnt < 16) slvRx[slvRxCnt] = capSh;
      slvRxCnt = slvRxCnt + 1;
      capBits = 0;
    end
    if (riseCnt < 64) riseCycle[riseCnt] = cyc;
    riseCnt = riseCnt + 1;
  end

  always @(negedge sclk) begin
    outBits = outBits + 1;
    if (outBits == 8) begin
      outBits = 0;
      slvIdx = slvIdx + 1;
      misoSh = slvTx[slvIdx % 16];
    end else begin
      misoSh = misoSh << 1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic slaveSetup(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    slvTx[0] = b0; slvTx[1] = b1; slvTx[2] = b2;
    for (int i = 3; i < 16; i++) slvTx[i] = 8'h00;
    slvIdx = 0; slvRxCnt = 0; capBits = 0; outBits = 0; riseCnt = 0;
    misoSh = b0;
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk); wrStrobe = 1'b1; wrData = d;
    @(negedge clk); wrStrobe = 1'b0;
  endtask

  task automatic doRead();
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  task automatic t_reset();
    check(txEmpty == 1'b1, "R13 txEmpty", txEmpty, 1);
    check(rxFull == 1'b0 && overrun == 1'b0, "R13 rxFull/overrun", {rxFull, overrun}, 0);
    check(busy == 1'b0 && sclk == 1'b0, "R13 busy/sclk", {busy, sclk}, 0);
  endtask

  task automatic t_single(input int h, input logic [7:0] txv, input logic [7:0] rxv);
    int effH;
    int n;
    effH = (h == 0) ? 1 : h;
    divHalf = DIV_W'(h);
    slaveSetup(rxv, 8'h00, 8'h00);
    doWrite(txv);
    check(txEmpty == 1'b0, "R1 txEmpty after write", txEmpty, 0);
    @(negedge clk);
    check(txEmpty == 1'b1 && sclk == 1'b0 && riseCnt == 0, "R2 txEmpty before first edge",
          {txEmpty, sclk}, 2);
    check(busy == 1'b1, "R12 busy at frame start", busy, 1);
    n = 0;
    while (!rxFull && n < 1000) begin @(negedge clk); n++; end
    check(n == 16 * effH, "R9 R3 cycles to rxFull", n, 16 * effH);
    check(busy == 1'b0 && sclk == 1'b0, "R5 idle after frame", {busy, sclk}, 0);
    check(rdData == rxv, "R3 received frame", rdData, rxv);
    check(slvRxCnt == 1 && slvRx[0] == txv, "R8 MOSI frame", slvRx[0], txv);
    check(riseCnt == 8, "R8 rising edges per frame", riseCnt, 8);
    doRead();
    check(rxFull == 1'b0 && rdData == rxv, "R11 read clears rxFull", {rxFull, rdData}, {1'b0, rxv});
  endtask

  task automatic t_backToBack();
    int bad;
    int n;
    divHalf = DIV_W'(2);
    slaveSetup(8'h81, 8'h42, 8'hE7);
    doWrite(8'h1E);
    @(negedge clk);
    doWrite(8'h2D);
    check(txEmpty == 1'b0 && busy == 1'b1, "R1 second frame queued", {txEmpty, busy}, 2);
    n = 0;
    while (!txEmpty && n < 1000) begin @(negedge clk); n++; end
    doWrite(8'h3C);
    doRead();
    check(rdData == 8'h81 && rxFull == 1'b0, "R11 first frame read", rdData, 8'h81);
    n = 0;
    while (!txEmpty && n < 1000) begin @(negedge clk); n++; end
    check(rxFull == 1'b1, "R7 rxFull N before txEmpty N+2", rxFull, 1);
    check(busy == 1'b1, "R12 busy across boundary", busy, 1);
    doRead();
    check(rdData == 8'h42, "R3 second frame", rdData, 8'h42);
    waitIdle();
    check(rdData == 8'hE7 && overrun == 1'b0, "R3 third frame no overrun", rdData, 8'hE7);
    check(slvRxCnt == 3 && slvRx[0] == 8'h1E && slvRx[1] == 8'h2D && slvRx[2] == 8'h3C,
          "R8 stream order", slvRxCnt, 3);
    bad = 0;
    for (int i = 1; i < 24; i++) if (riseCycle[i] - riseCycle[i-1] != 4) bad++;
    check(riseCnt == 24 && bad == 0, "R4 continuous clock", bad, 0);
    doRead();
  endtask

  task automatic t_overrun();
    divHalf = DIV_W'(1);
    slaveSetup(8'h55, 8'hAA, 8'h00);
    doWrite(8'h11);
    @(negedge clk);
    doWrite(8'h22);
    @(negedge clk);
    waitIdle();
    check(overrun == 1'b1 && rxFull == 1'b1, "R6 overrun set", {overrun, rxFull}, 3);
    check(rdData == 8'hAA, "R6 newest frame kept", rdData, 8'hAA);
    doRead();
    check(overrun == 1'b1, "R6 overrun sticky over read", overrun, 1);
    @(negedge clk); ovrClr = 1'b1;
    @(negedge clk); ovrClr = 1'b0;
    check(overrun == 1'b0, "R6 overrun cleared", overrun, 0);
  endtask

  task automatic t_ignored();
    divHalf = DIV_W'(1);
    slaveSetup(8'h0F, 8'hF0, 8'h00);
    doWrite(8'h66);
    @(negedge clk);
    doWrite(8'h77);
    check(txEmpty == 1'b0, "R10 buffer full before extra write", txEmpty, 0);
    doWrite(8'h99);
    @(negedge clk);
    waitIdle();
    repeat (4) @(negedge clk);
    check(slvRxCnt == 2 && slvRx[1] == 8'h77, "R10 extra write ignored", slvRx[1], 8'h77);
    check(riseCnt == 16 && txEmpty == 1'b1, "R10 no third frame", riseCnt, 16);
    doRead();
    @(negedge clk); ovrClr = 1'b1;
    @(negedge clk); ovrClr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    slaveSetup(8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(0, 8'hA5, 8'h3C);
    t_single(3, 8'h5A, 8'hC3);
    t_single(15, 8'h80, 8'h01);
    t_backToBack();
    t_overrun();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule